// File: doc/BRIEF.md
# Shared Interrupt Target Router

This block sits beside the interrupt distributor. It holds the target CPU of each shared interrupt and decides, for every CPU, whether that CPU has an interrupt it can take. Software reaches the targets through a word-wide register port. Each word carries four one-byte target fields, and bit n of a byte stands for CPU n. Whatever pattern is written, each byte is reduced to exactly one CPU. A read therefore always returns one set bit per byte.

The pending and enable vectors come from outside the block. Private interrupts are supplied per CPU and shared interrupts as one vector each. The block combines them with the stored routing and the global enable, and produces one registered pending flag per CPU. It also keeps an in-service bit for each shared level-triggered interrupt. While that bit is set, the interrupt's line is not counted as pending, and an end-of-interrupt notification clears the bit.

Top module: `irq_target_router`

## Requirements
- R1: On a write to a shared target word, the target of each byte lane is the lowest set bit of that byte among bits 0 to NUM_CPUS-1. Bits at or above NUM_CPUS are ignored. Word w, byte lane b (bits 8b+7..8b) holds interrupt 4w+b, and words 0 to 7 cover interrupts 0 to 31.
- R2: A byte with no set bit in bits 0 to NUM_CPUS-1 selects CPU 0.
- R3: Reading a shared target word returns, in each byte, the one-hot code of the stored target (bit n set for CPU n).
- R4: Target words 0 to 7 ignore writes. On a read, each of their four bytes returns the one-hot code of the accessing CPU given on `reg_cpu_i`.
- R5: A private interrupt raises the flag of its own CPU when it is both pending and enabled. Private interrupt i of CPU c sits at bit 32c+i of the private vectors.
- R6: A shared interrupt raises the flag only of its target CPU, and only when it is pending, enabled and not in service.
- R7: Delivering a shared interrupt whose level bit is 1 sets its in-service bit, which masks it from the pending flags. An end of interrupt for the same index clears the bit. Delivering an edge interrupt (level bit 0) does not mask it. A set wins over a clear in the same cycle.
- R8: While `dist_en_i` is 0, `cpu_pend_o` equals 1: CPU 0's flag is set and every other flag is clear.
- R9: After reset every shared target is CPU 0, every in-service bit is clear and `cpu_pend_o` is 0.
- R10: Read data appears on `reg_rdata_o` on the clock edge that accepts the read. `cpu_pend_o` is registered once from the current inputs and state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | AW | Target word index |
| reg_wdata_i | input | 32 | Write data, four target bytes |
| reg_cpu_i | input | CPU_W | Index of the accessing CPU |
| reg_rdata_o | output | 32 | Read data, registered |
| dist_en_i | input | 1 | Distributor global enable |
| priv_pend_i | input | NUM_CPUS*32 | Private pending, 32 bits per CPU |
| priv_en_i | input | NUM_CPUS*32 | Private enable, 32 bits per CPU |
| spi_pend_i | input | NUM_SPI | Shared pending |
| spi_en_i | input | NUM_SPI | Shared enable |
| spi_level_i | input | NUM_SPI | 1 = level-triggered, 0 = edge |
| dlv_i | input | 1 | An interrupt was delivered this cycle |
| dlv_idx_i | input | SW | Shared index of the delivered interrupt |
| eoi_i | input | 1 | End of interrupt this cycle |
| eoi_idx_i | input | SW | Shared index of the completed interrupt |
| cpu_pend_o | output | NUM_CPUS | Per-CPU deliverable-interrupt flags |

## Verification
The bench drives a read on a falling edge. The read is taken at the next rising edge, so the bench compares the data on the following falling edge. A change to the pending, enable or global-enable inputs shows on `cpu_pend_o` at the next rising edge, and the bench checks it half a cycle later. A target write or a delivery or end-of-interrupt notification first updates state at one rising edge. The flags reflect that state only at the next rising edge, so those checks wait two falling edges after the stimulus.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NUM_PRIV  = 32;
  localparam int LANES     = 4;
  localparam int LANE_W    = 8;
  localparam int BUS_W     = LANES * LANE_W;
  localparam int PRIV_WORDS = NUM_PRIV / LANES;
  typedef logic [BUS_W-1:0] bus_word_t;
endpackage

// File: rtl/irq_tgt_regs.sv
module irq_tgt_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_SPI  = 32,
  parameter int AW       = 4,
  parameter int CPU_W    = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  bus_word_t                wdata_i,
  input  logic [CPU_W-1:0]         cpu_i,
  output bus_word_t                rdata_o,
  output logic [NUM_SPI*CPU_W-1:0] tgt_o
);
  logic [CPU_W-1:0] tgt_q [NUM_SPI];
  bus_word_t        rd_d, rd_q;

  function automatic logic [CPU_W-1:0] pick_low(input logic [LANE_W-1:0] b);
    logic [CPU_W-1:0] r;
    r = '0;
    for (int i = NUM_CPUS - 1; i >= 0; i--)
      if (b[i]) r = CPU_W'(i);
    return r;
  endfunction

  function automatic logic [LANE_W-1:0] to_onehot(input logic [CPU_W-1:0] c);
    return LANE_W'(1) << c;
  endfunction

  for (genvar s = 0; s < NUM_SPI; s++) begin : g_tgt
    localparam int WORD = PRIV_WORDS + s / LANES;
    localparam int LANE = s % LANES;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        tgt_q[s] <= '0;
      else if (req_i && we_i && addr_i == AW'(WORD))
        tgt_q[s] <= pick_low(wdata_i[LANE*LANE_W +: LANE_W]);
    end
    assign tgt_o[s*CPU_W +: CPU_W] = tgt_q[s];
  end

  always_comb begin
    rd_d = '0;
    if (int'(addr_i) < PRIV_WORDS) begin
      rd_d = {LANES{to_onehot(cpu_i)}};
    end else begin
      for (int s = 0; s < NUM_SPI; s++)
        if (int'(addr_i) == PRIV_WORDS + s / LANES)
          rd_d[(s % LANES)*LANE_W +: LANE_W] = to_onehot(tgt_q[s]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rd_q <= '0;
    else if (req_i && !we_i)    rd_q <= rd_d;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/irq_active_trk.sv
module irq_active_trk #(
  parameter int NUM_SPI = 32,
  parameter int SW      = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dlv_i,
  input  logic [SW-1:0]      dlv_idx_i,
  input  logic               eoi_i,
  input  logic [SW-1:0]      eoi_idx_i,
  input  logic [NUM_SPI-1:0] level_i,
  output logic [NUM_SPI-1:0] active_o
);
  for (genvar s = 0; s < NUM_SPI; s++) begin : g_act
    logic set_s, clr_s, act_q;
    assign set_s = dlv_i && dlv_idx_i == SW'(s) && level_i[s];
    assign clr_s = eoi_i && eoi_idx_i == SW'(s);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) act_q <= 1'b0;
      else         act_q <= set_s | (act_q & ~clr_s);
    end
    assign active_o[s] = act_q;
  end
endmodule

// File: rtl/irq_pend_calc.sv
module irq_pend_calc
  import irq_router_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_SPI  = 32,
  parameter int CPU_W    = 2
) (
  input  logic [NUM_CPUS*NUM_PRIV-1:0] priv_pend_i,
  input  logic [NUM_CPUS*NUM_PRIV-1:0] priv_en_i,
  input  logic [NUM_SPI-1:0]           spi_pend_i,
  input  logic [NUM_SPI-1:0]           spi_en_i,
  input  logic [NUM_SPI-1:0]           active_i,
  input  logic [NUM_SPI*CPU_W-1:0]     tgt_i,
  input  logic                         dist_en_i,
  output logic [NUM_CPUS-1:0]          pend_o
);
  logic [NUM_SPI-1:0]  spi_live;
  logic [NUM_CPUS-1:0] raw;

  assign spi_live = spi_pend_i & spi_en_i & ~active_i;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_SPI-1:0] hit;
    for (genvar s = 0; s < NUM_SPI; s++) begin : g_hit
      assign hit[s] = tgt_i[s*CPU_W +: CPU_W] == CPU_W'(c);
    end
    assign raw[c] = |(priv_pend_i[c*NUM_PRIV +: NUM_PRIV] & priv_en_i[c*NUM_PRIV +: NUM_PRIV])
                  | |(spi_live & hit);
  end

  assign pend_o = dist_en_i ? raw : NUM_CPUS'(1);
endmodule

// File: rtl/irq_target_router.sv
module irq_target_router
  import irq_router_pkg::*;
#(
  parameter  int NUM_CPUS = 4,
  parameter  int NUM_IRQS = 64,
  localparam int NUM_SPI  = NUM_IRQS - NUM_PRIV,
  localparam int WORDS    = NUM_IRQS / LANES,
  localparam int AW       = $clog2(WORDS),
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int SW       = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         reg_req_i,
  input  logic                         reg_we_i,
  input  logic [AW-1:0]                reg_addr_i,
  input  logic [BUS_W-1:0]             reg_wdata_i,
  input  logic [CPU_W-1:0]             reg_cpu_i,
  output logic [BUS_W-1:0]             reg_rdata_o,
  input  logic                         dist_en_i,
  input  logic [NUM_CPUS*NUM_PRIV-1:0] priv_pend_i,
  input  logic [NUM_CPUS*NUM_PRIV-1:0] priv_en_i,
  input  logic [NUM_SPI-1:0]           spi_pend_i,
  input  logic [NUM_SPI-1:0]           spi_en_i,
  input  logic [NUM_SPI-1:0]           spi_level_i,
  input  logic                         dlv_i,
  input  logic [SW-1:0]                dlv_idx_i,
  input  logic                         eoi_i,
  input  logic [SW-1:0]                eoi_idx_i,
  output logic [NUM_CPUS-1:0]          cpu_pend_o
);
  logic [NUM_SPI*CPU_W-1:0] tgt_flat;
  logic [NUM_SPI-1:0]       active_q;
  logic [NUM_CPUS-1:0]      pend_d, pend_q;

  irq_tgt_regs #(.NUM_CPUS(NUM_CPUS), .NUM_SPI(NUM_SPI), .AW(AW), .CPU_W(CPU_W)) u_regs (
    .clk_i, .rst_ni,
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .cpu_i(reg_cpu_i), .rdata_o(reg_rdata_o),
    .tgt_o(tgt_flat)
  );

  irq_active_trk #(.NUM_SPI(NUM_SPI), .SW(SW)) u_act (
    .clk_i, .rst_ni,
    .dlv_i, .dlv_idx_i, .eoi_i, .eoi_idx_i,
    .level_i(spi_level_i), .active_o(active_q)
  );

  irq_pend_calc #(.NUM_CPUS(NUM_CPUS), .NUM_SPI(NUM_SPI), .CPU_W(CPU_W)) u_calc (
    .priv_pend_i, .priv_en_i, .spi_pend_i, .spi_en_i,
    .active_i(active_q), .tgt_i(tgt_flat), .dist_en_i, .pend_o(pend_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign cpu_pend_o = pend_q;
endmodule

// File: rtl/irq_target_router_chk.sv
module irq_target_router_chk
  import irq_router_pkg::*;
#(
  parameter  int NUM_CPUS = 4,
  parameter  int NUM_IRQS = 64,
  localparam int NUM_SPI  = NUM_IRQS - NUM_PRIV,
  localparam int WORDS    = NUM_IRQS / LANES,
  localparam int AW       = $clog2(WORDS),
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int SW       = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     reg_req_i,
  input logic                     reg_we_i,
  input logic [AW-1:0]            reg_addr_i,
  input logic [CPU_W-1:0]         reg_cpu_i,
  input logic [BUS_W-1:0]         reg_rdata_o,
  input logic                     dist_en_i,
  input logic [NUM_SPI-1:0]       spi_level_i,
  input logic                     dlv_i,
  input logic [SW-1:0]            dlv_idx_i,
  input logic                     eoi_i,
  input logic [SW-1:0]            eoi_idx_i,
  input logic [NUM_CPUS-1:0]      cpu_pend_o,
  input logic [NUM_SPI*CPU_W-1:0] tgt_flat,
  input logic [NUM_SPI-1:0]       active_q
);
  logic priv_word, shr_word;
  assign priv_word = int'(reg_addr_i) < PRIV_WORDS;
  assign shr_word  = !priv_word && int'(reg_addr_i) < WORDS;

  assert_priv_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && !reg_we_i && priv_word |=>
      reg_rdata_o == {LANES{LANE_W'(1) << $past(reg_cpu_i)}});

  assert_priv_write_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && reg_we_i && priv_word |=> $stable(tgt_flat));

  assert_read_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && !reg_we_i && shr_word |=>
      $countones(reg_rdata_o[7:0]) == 1 && $countones(reg_rdata_o[15:8]) == 1 &&
      $countones(reg_rdata_o[23:16]) == 1 && $countones(reg_rdata_o[31:24]) == 1);

  assert_disabled_cpu0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dist_en_i |=> cpu_pend_o == NUM_CPUS'(1));

  assert_level_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_i && spi_level_i[dlv_idx_i] |=> active_q[$past(dlv_idx_i)]);

  assert_eoi_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_i && !(dlv_i && dlv_idx_i == eoi_idx_i) |=> !active_q[$past(eoi_idx_i)]);
endmodule

bind irq_target_router irq_target_router_chk #(.NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS)) u_chk (.*);

// File: tb/irq_target_router_test.sv
module irq_target_router_test;
  localparam int NC = 4;
  localparam int NI = 64;
  localparam int NS = NI - 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0] cpu = '0;
  logic dist_en = 1'b1;
  logic [NC*32-1:0] ppend = '0, pen = '0;
  logic [NS-1:0] spend = '0, sen = '0, slvl = '0;
  logic dlv = 0, eoi = 0;
  logic [4:0] dlv_idx = '0, eoi_idx = '0;
  logic [NC-1:0] cpu_pend;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_target_router #(.NUM_CPUS(NC), .NUM_IRQS(NI)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_cpu_i(cpu), .reg_rdata_o(rdata),
    .dist_en_i(dist_en), .priv_pend_i(ppend), .priv_en_i(pen),
    .spi_pend_i(spend), .spi_en_i(sen), .spi_level_i(slvl),
    .dlv_i(dlv), .dlv_idx_i(dlv_idx), .eoi_i(eoi), .eoi_idx_i(eoi_idx),
    .cpu_pend_o(cpu_pend)
  );

  typedef struct packed {
    logic [3:0]  a;
    logic [31:0] wd;
    logic [1:0]  c;
    logic [31:0] exp;
  } vec_t;

  // write then read back; words 8.. hold shared interrupts 0..
  localparam vec_t VEC [6] = '{
    '{a: 4'd8,  wd: 32'h08040201, c: 2'd0, exp: 32'h08040201},
    '{a: 4'd9,  wd: 32'h0C0603FF, c: 2'd0, exp: 32'h04020101},
    '{a: 4'd10, wd: 32'h00F00A00, c: 2'd0, exp: 32'h01010201},
    '{a: 4'd15, wd: 32'h80402010, c: 2'd0, exp: 32'h01010101},
    '{a: 4'd15, wd: 32'h0F0E0C08, c: 2'd0, exp: 32'h01020408},
    '{a: 4'd3,  wd: 32'hFFFFFFFF, c: 2'd1, exp: 32'h02020202}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [1:0] c);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d; cpu = c;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] c, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a; cpu = c;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 flags after reset", 32'(cpu_pend), 32'h0);
    rd(4'd8, 2'd0, d);  chk("R9 target reset word 8", d, 32'h01010101);
    rd(4'd15, 2'd0, d); chk("R9 target reset word 15", d, 32'h01010101);

    for (int i = 0; i < 6; i++) begin
      wr(VEC[i].a, VEC[i].wd, VEC[i].c);
      rd(VEC[i].a, VEC[i].c, d);
      chk((i == 5) ? "R4 private word write ignored" : "R1 R2 R3 lane select", d, VEC[i].exp);
    end
    rd(4'd0, 2'd2, d); chk("R4 private read cpu2", d, 32'h04040404);
    rd(4'd7, 2'd3, d); chk("R10 R4 private read cpu3", d, 32'h08080808);

    // targets now: s1->cpu1, s6->cpu1, s28->cpu3, s9->cpu1
    @(negedge clk); spend = 32'h2; sen = 32'h2;
    @(negedge clk); chk("R6 shared s1 to cpu1", 32'(cpu_pend), 32'h2);
    @(negedge clk); sen = '0;
    @(negedge clk); chk("R6 shared disabled", 32'(cpu_pend), 32'h0);
    @(negedge clk); spend = 32'h1000_0000; sen = 32'h1000_0000;
    @(negedge clk); chk("R6 shared s28 to cpu3", 32'(cpu_pend), 32'h8);
    @(negedge clk); spend = '0; sen = '0; ppend[2*32+5] = 1'b1;
    @(negedge clk); chk("R5 private pending not enabled", 32'(cpu_pend), 32'h0);
    @(negedge clk); pen[2*32+5] = 1'b1;
    @(negedge clk); chk("R5 private cpu2", 32'(cpu_pend), 32'h4);
    @(negedge clk); dist_en = 1'b0;
    @(negedge clk); chk("R8 global disable", 32'(cpu_pend), 32'h1);
    @(negedge clk); dist_en = 1'b1; ppend = '0; pen = '0;
    @(negedge clk); chk("R10 flags follow next edge", 32'(cpu_pend), 32'h0);

    // level interrupt s6 -> cpu1
    @(negedge clk); spend[6] = 1; sen[6] = 1; slvl[6] = 1;
    @(negedge clk); chk("R7 level pending", 32'(cpu_pend), 32'h2);
    dlv = 1; dlv_idx = 5'd6;
    @(negedge clk); dlv = 0;
    @(negedge clk); chk("R7 in service masked", 32'(cpu_pend), 32'h0);
    eoi = 1; eoi_idx = 5'd6;
    @(negedge clk); eoi = 0;
    @(negedge clk); chk("R7 eoi resamples", 32'(cpu_pend), 32'h2);
    // set beats clear in same cycle
    dlv = 1; dlv_idx = 5'd6; eoi = 1; eoi_idx = 5'd6;
    @(negedge clk); dlv = 0; eoi = 0;
    @(negedge clk); chk("R7 set wins over clear", 32'(cpu_pend), 32'h0);
    eoi = 1; eoi_idx = 5'd6;
    @(negedge clk); eoi = 0; slvl[6] = 0;
    settle();
    dlv = 1; dlv_idx = 5'd6;
    @(negedge clk); dlv = 0;
    @(negedge clk); chk("R7 edge not masked", 32'(cpu_pend), 32'h2);

    // retarget s6 (word 9 lane 2) to cpu0 via zero byte
    wr(4'd9, 32'h00000000, 2'd0);
    @(negedge clk); chk("R2 zero byte routes to cpu0", 32'(cpu_pend), 32'h1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule